// File: doc/BRIEF.md
# Page Code Comparator and Single-Bit Corrector

This block sits on the read path of a paged non-volatile store. For each 256-byte page it receives two 22-bit check codes: the code that was saved with the page, and the code recomputed from the data just read back. It XORs the two into a syndrome and classifies the page into one of four outcomes: clean, a single correctable data bit, a flip in the saved code itself, or uncorrectable.

For a correctable data flip, the block also reports the byte address (0 to 255) and the bit index (0 to 7) of the failing bit. A downstream page buffer uses these to invert that bit. The syndrome is arranged as eleven complementary pairs. Three pairs select the bit inside a byte and eight pairs select the byte. A genuine single data flip sets exactly one member of every pair. Two data flips either clear both members of a pair or set both, so such pages are never corrected by mistake.

The block samples its inputs when `in_valid` is high. One clock later it presents a registered result together with `out_valid`.

Top module: `page_code_cmp`

## Requirements
- R1: The outcome depends only on the bitwise XOR (syndrome) of `stored_code` and `fresh_code`. Two input pairs with the same syndrome give identical results.
- R2: An all-zero syndrome gives `status` 2'b00 (clean).
- R3: A syndrome with exactly one bit set gives `status` 2'b10 (flip in the saved code, data good).
- R4: Syndrome pair k is bits {2k+1, 2k}. Bit 2k+1 is the "one" member and bit 2k is the "zero" member. When every pair has exactly one member set, which means 11 of 22 bits are set, `status` is 2'b01. `err_bit[k]` equals bit 2k+1 for k = 0..2, and `err_byte[j]` equals bit 2(j+3)+1 for j = 0..7.
- R5: A syndrome with 11 bits set in which some pair has both members set or neither set gives `status` 2'b11.
- R6: Every other syndrome gives `status` 2'b11. This includes any two flipped data bits, two flipped code bits, and a data flip combined with a code flip.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. While `in_valid` is low, `status`, `err_byte` and `err_bit` keep their values.
- R8: After reset, `out_valid`, `status`, `err_byte` and `err_bit` are all zero.
- R9: `err_byte` and `err_bit` are zero whenever `status` is not 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Codes are presented this cycle |
| stored_code | input | 22 | Check code saved with the page |
| fresh_code | input | 22 | Check code recomputed on readback |
| out_valid | output | 1 | Result registers hold a new result |
| status | output | 2 | 00 clean, 01 corrected, 10 code flip, 11 uncorrectable |
| err_byte | output | 8 | Failing byte address when corrected |
| err_bit | output | 3 | Failing bit index when corrected |

## Verification
Each result is due exactly one rising edge after the cycle in which `in_valid` is sampled high. That edge is the only register between the inputs and the outputs. The bench drives inputs on the falling edge, holds `in_valid` for one cycle, and reads every output at the next falling edge, half a period after the capturing edge. The hold behaviour is checked at that same falling edge after an idle cycle with changed input codes. The reset values are checked one falling edge after `rst_n` is asserted.

// File: rtl/page_code_pkg.sv
package page_code_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN   = 2'b00,
        ST_FIXED   = 2'b01,
        ST_CODEERR = 2'b10,
        ST_FATAL   = 2'b11
    } verdict_e;

    function automatic int unsigned ones_count(input logic [63:0] v, input int unsigned w);
        int unsigned n;
        n = 0;
        for (int unsigned i = 0; i < 64; i++) begin
            if (i < w && v[i]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/code_syndrome.sv
module code_syndrome #(
    parameter int unsigned WIDTH = 22,
    localparam int unsigned CW = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] code_a,
    input  logic [WIDTH-1:0] code_b,
    output logic [WIDTH-1:0] syn,
    output logic [CW-1:0]    syn_ones
);
    logic [63:0] wide;

    always_comb begin
        syn  = code_a ^ code_b;
        wide = '0;
        wide[WIDTH-1:0] = syn;
        syn_ones = CW'(page_code_pkg::ones_count(wide, WIDTH));
    end
endmodule

// File: rtl/pair_locator.sv
module pair_locator #(
    parameter int unsigned COL_PAIRS  = 3,
    parameter int unsigned LINE_PAIRS = 8,
    localparam int unsigned PAIRS = COL_PAIRS + LINE_PAIRS,
    localparam int unsigned WIDTH = 2 * PAIRS
) (
    input  logic [WIDTH-1:0]      syn,
    output logic                  all_split,
    output logic [LINE_PAIRS-1:0] line_idx,
    output logic [COL_PAIRS-1:0]  col_idx
);
    logic [PAIRS-1:0] split;
    logic [PAIRS-1:0] upper;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        assign split[k] = syn[2*k] ^ syn[2*k+1];
        assign upper[k] = syn[2*k+1];
    end

    assign all_split = &split;
    assign col_idx   = upper[COL_PAIRS-1:0];
    assign line_idx  = upper[PAIRS-1:COL_PAIRS];

    // R4: an all-split syndrome always carries exactly one bit per pair
    always_comb begin
        if (all_split === 1'b1)
            assert_split_weight_R4: assert (page_code_pkg::ones_count({{(64-WIDTH){1'b0}}, syn}, WIDTH) == PAIRS);
    end
endmodule

// File: rtl/page_code_cmp.sv
module page_code_cmp #(
    parameter int unsigned COL_PAIRS  = 3,
    parameter int unsigned LINE_PAIRS = 8,
    localparam int unsigned PAIRS = COL_PAIRS + LINE_PAIRS,
    localparam int unsigned WIDTH = 2 * PAIRS,
    localparam int unsigned CW    = $clog2(WIDTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [WIDTH-1:0]      stored_code,
    input  logic [WIDTH-1:0]      fresh_code,
    output logic                  out_valid,
    output logic [1:0]            status,
    output logic [LINE_PAIRS-1:0] err_byte,
    output logic [COL_PAIRS-1:0]  err_bit
);
    import page_code_pkg::*;

    typedef struct packed {
        logic                  valid;
        verdict_e              verdict;
        logic [LINE_PAIRS-1:0] line;
        logic [COL_PAIRS-1:0]  col;
    } res_t;

    logic [WIDTH-1:0]      syn;
    logic [CW-1:0]         syn_ones;
    logic                  all_split;
    logic [LINE_PAIRS-1:0] line_idx;
    logic [COL_PAIRS-1:0]  col_idx;
    res_t                  res_d, res_q;

    code_syndrome #(.WIDTH(WIDTH)) u_syn (
        .code_a   (stored_code),
        .code_b   (fresh_code),
        .syn      (syn),
        .syn_ones (syn_ones)
    );

    pair_locator #(.COL_PAIRS(COL_PAIRS), .LINE_PAIRS(LINE_PAIRS)) u_loc (
        .syn       (syn),
        .all_split (all_split),
        .line_idx  (line_idx),
        .col_idx   (col_idx)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.line = '0;
            res_d.col  = '0;
            if (syn_ones == CW'(0)) begin
                res_d.verdict = ST_CLEAN;
            end else if (syn_ones == CW'(1)) begin
                res_d.verdict = ST_CODEERR;
            end else if (syn_ones == CW'(PAIRS) && all_split) begin
                res_d.verdict = ST_FIXED;
                res_d.line    = line_idx;
                res_d.col     = col_idx;
            end else begin
                res_d.verdict = ST_FATAL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign status    = res_q.verdict;
    assign err_byte  = res_q.line;
    assign err_bit   = res_q.col;

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(status) && $stable(err_byte) && $stable(err_bit)));
    assert_addr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'b01) |-> (err_byte == '0 && err_bit == '0));
    assert_equal_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && stored_code == fresh_code) |=> status == 2'b00);
    assert_single_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $countones(stored_code ^ fresh_code) == 1) |=> status == 2'b10);
    assert_even_never_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $countones(stored_code ^ fresh_code) != PAIRS
                  && $countones(stored_code ^ fresh_code) > 1) |=> status == 2'b11);
endmodule

// File: tb/page_code_cmp_tb.sv
module page_code_cmp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [21:0] stored_code = '0;
    logic [21:0] fresh_code = '0;
    logic        out_valid;
    logic [1:0]  status;
    logic [7:0]  err_byte;
    logic [2:0]  err_bit;
    int          n_checks = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    page_code_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .stored_code(stored_code), .fresh_code(fresh_code),
        .out_valid(out_valid), .status(status),
        .err_byte(err_byte), .err_bit(err_bit)
    );

    // syndrome of one flipped data bit: pair k -> bit 2k+1 if address bit is 1, else 2k
    function automatic logic [21:0] flip_syn(input logic [7:0] a, input logic [2:0] b);
        logic [21:0] s;
        logic [10:0] sel;
        s   = '0;
        sel = {a, b};
        for (int k = 0; k < 11; k++) s[2*k + (sel[k] ? 1 : 0)] = 1'b1;
        return s;
    endfunction

    typedef struct packed {
        logic [21:0] stored;
        logic [21:0] syn;
        logic [1:0]  st;
        logic [7:0]  byt;
        logic [2:0]  bt;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{22'h000000, 22'h000000,                              2'b00, 8'h00, 3'd0}, // R2
        '{22'h2F0C31, 22'h000000,                              2'b00, 8'h00, 3'd0}, // R2, R1
        '{22'h000000, 22'h000001,                              2'b10, 8'h00, 3'd0}, // R3
        '{22'h13579B, 22'h200000,                              2'b10, 8'h00, 3'd0}, // R3
        '{22'h000000, flip_syn(8'h00, 3'd0),                   2'b01, 8'h00, 3'd0}, // R4
        '{22'h000000, flip_syn(8'hFF, 3'd7),                   2'b01, 8'hFF, 3'd7}, // R4
        '{22'h000000, flip_syn(8'hA5, 3'd3),                   2'b01, 8'hA5, 3'd3}, // R4
        '{22'h3C3C3C, flip_syn(8'hA5, 3'd3),                   2'b01, 8'hA5, 3'd3}, // R4, R1
        '{22'h000000, 22'h155553,                              2'b11, 8'h00, 3'd0}, // R5
        '{22'h000000, flip_syn(8'h10, 3'd2) ^ flip_syn(8'h11, 3'd2), 2'b11, 8'h00, 3'd0}, // R6
        '{22'h000000, flip_syn(8'h00, 3'd0) ^ flip_syn(8'hFF, 3'd7), 2'b11, 8'h00, 3'd0}, // R6
        '{22'h000000, 22'h000003,                              2'b11, 8'h00, 3'd0}, // R6
        '{22'h000000, flip_syn(8'h3C, 3'd5) ^ 22'h000400,      2'b11, 8'h00, 3'd0}, // R6
        '{22'h000000, 22'h0F0000,                              2'b11, 8'h00, 3'd0}  // R6
    };

    task automatic check(input string req, input logic [13:0] got, input logic [13:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got v=%0b st=%b byte=%h bit=%0d, expected v=%0b st=%b byte=%h bit=%0d",
                     req, got[13], got[12:11], got[10:3], got[2:0],
                     exp[13], exp[12:11], exp[10:3], exp[2:0]);
        end
    endtask

    task automatic present(input logic [21:0] s, input logic [21:0] f);
        @(negedge clk);
        stored_code = s; fresh_code = f; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", {out_valid, status, err_byte, err_bit}, 14'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            present(VEC[i].stored, VEC[i].stored ^ VEC[i].syn);
            check($sformatf("vector %0d (R1-R6 row)", i),
                  {out_valid, status, err_byte, err_bit},
                  {1'b1, VEC[i].st, VEC[i].byt, VEC[i].bt});
        end

        // R9: address fields cleared after a corrected page is followed by a fatal one
        present(22'h0, flip_syn(8'h7E, 3'd6));
        check("R4", {out_valid, status, err_byte, err_bit}, {1'b1, 2'b01, 8'h7E, 3'd6});
        present(22'h0, 22'h3FFFFF);
        check("R9", {out_valid, status, err_byte, err_bit}, {1'b1, 2'b11, 8'h00, 3'd0});

        // R7: idle cycle with changed inputs keeps results and drops out_valid
        present(22'h0, flip_syn(8'h81, 3'd1));
        @(negedge clk);
        stored_code = 22'h0; fresh_code = 22'h000002;
        @(negedge clk);
        check("R7", {out_valid, status, err_byte, err_bit}, {1'b0, 2'b01, 8'h81, 3'd1});

        // R7: back-to-back inputs give one result per cycle
        @(negedge clk);
        stored_code = 22'h0; fresh_code = 22'h000010; in_valid = 1'b1;
        @(negedge clk);
        check("R7", {out_valid, status, err_byte, err_bit}, {1'b1, 2'b10, 8'h00, 3'd0});
        fresh_code = flip_syn(8'h42, 3'd4);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7", {out_valid, status, err_byte, err_bit}, {1'b1, 2'b01, 8'h42, 3'd4});

        // R8: reset in the middle of a run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8", {out_valid, status, err_byte, err_bit}, 14'h0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end
endmodule